// File: doc/BRIEF.md
# Stereo Audio Serial Receiver

This block turns a three-wire serial audio stream into parallel stereo samples. A word clock splits every frame into two slots. The left slot runs while the word clock is high and the right slot while it is low. A bit clock paces the data line, and its intended rate is 64 times the sample rate, which gives 32 bit periods per slot. All three serial lines are asynchronous to the system clock. They pass through matched two-stage synchronizers, so they keep their alignment to each other.

Two run-time controls set how a slot is decoded. One selects a 16-bit or 20-bit sample length. The other selects whether the most significant or the least significant bit arrives first. A new setting is taken only at a word-clock rising edge. When the right sample is complete, both samples appear together on 20-bit outputs with a one-cycle strobe. A framing flag reports any frame whose length is not 64 bit periods.

Top module: `stereo_serial_rx`

## Requirements
- R1: A word-clock rising edge, seen at a bit-clock rising edge, starts a frame. That bit is slot position 0 of the left channel. The left slot lasts while the word clock is high, and the right slot starts at the first bit with the word clock low.
- R2: Data is sampled only at bit-clock rising edges. The bit clock, word clock and data inputs are asynchronous and are synchronized internally.
- R3: cfg_w20_i = 1 selects 20-bit samples and 0 selects 16-bit samples. Data at slot positions equal to or beyond the sample length is ignored.
- R4: A 16-bit sample is sign-extended to 20 bits, so bits 19..16 equal bit 15.
- R5: cfg_lsb_i = 0 means the slot starts with the most significant bit. cfg_lsb_i = 1 means it starts with bit 0. The output always holds the value in normal numeric order.
- R6: valid_o pulses for exactly one clock after the last data bit of a right slot, and only if the left slot of the same frame completed. left_o and right_o change only with that pulse.
- R7: The configuration inputs are sampled only at a word-clock rising edge. A change in mid-frame does not affect the frame in progress.
- R8: At each word-clock rising edge, frame_err_o is set if the frame just ended did not contain exactly 64 bit-clock rising edges, and cleared otherwise. It then holds until the next frame start. The first frame start after reset reports no error.
- R9: During reset, valid_o, frame_err_o, left_o and right_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_i | input | 1 | Serial bit clock |
| wclk_i | input | 1 | Word clock (high = left slot) |
| sdata_i | input | 1 | Serial data |
| cfg_w20_i | input | 1 | 1 = 20-bit samples, 0 = 16-bit |
| cfg_lsb_i | input | 1 | 1 = LSB first, 0 = MSB first |
| left_o | output | 20 | Left sample |
| right_o | output | 20 | Right sample |
| valid_o | output | 1 | One-cycle strobe for a new sample pair |
| frame_err_o | output | 1 | Previous frame length was not 64 bits |

## Verification
The embedded properties watch four things on every cycle:
- the strobe lasts a single clock;
- the outputs hold between strobes;
- 16-bit results carry a correct sign extension;
- the framing flag moves only on a detected frame start.

Correct bit placement in both orders and both lengths, the discarding of padding bits, the isolation of a frame from a mid-frame configuration change, and the framing verdict for short, long and exact frames depend on whole serial sequences. Only the bench scenarios can show these, by comparing against values rebuilt from the transmitted samples.

// File: rtl/stereo_serial_rx.sv
module stereo_serial_rx #(
  parameter int SLOT_BITS = 32,
  parameter int W_LONG    = 20,
  parameter int W_SHORT   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_i,
  input  logic              wclk_i,
  input  logic              sdata_i,
  input  logic              cfg_w20_i,
  input  logic              cfg_lsb_i,
  output logic [W_LONG-1:0] left_o,
  output logic [W_LONG-1:0] right_o,
  output logic              valid_o,
  output logic              frame_err_o
);
  localparam int PW         = $clog2(SLOT_BITS);
  localparam int IW         = $clog2(W_LONG);
  localparam int FRAME_BITS = 2 * SLOT_BITS;
  localparam int CW         = $clog2(FRAME_BITS) + 2;
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [2:0] bclk_sy, wclk_sy, sd_sy;
  logic       wprev, synced, left_ok, w20_q, lsb_q;
  logic [PW-1:0] pos;
  logic [CW-1:0] cnt;
  logic [W_LONG-1:0] acc, acc_nxt, left_hold, ext;

  wire ev    = bclk_sy[1] & ~bclk_sy[2];
  wire wclk_s = wclk_sy[1];
  wire sd_s   = sd_sy[1];
  wire wr_ev = ev & wclk_s & ~wprev;
  wire wf_ev = ev & ~wclk_s & wprev;

  wire eff_w20 = wr_ev ? cfg_w20_i : w20_q;
  wire eff_lsb = wr_ev ? cfg_lsb_i : lsb_q;
  wire [PW-1:0] wlen    = eff_w20 ? PW'(W_LONG) : PW'(W_SHORT);
  wire [PW-1:0] pos_eff = (wr_ev | wf_ev) ? '0 : pos;
  wire [PW-1:0] msb_idx = wlen - PW'(1) - pos_eff;
  wire [IW-1:0] idx     = eff_lsb ? IW'(pos_eff) : IW'(msb_idx);
  wire in_range = pos_eff < wlen;
  wire last_bit = in_range && (pos_eff == wlen - PW'(1));

  always_comb begin
    acc_nxt = (pos_eff == '0) ? '0 : acc;
    if (in_range) acc_nxt[idx] = sd_s;
    ext = eff_w20 ? acc_nxt
                  : {{(W_LONG-W_SHORT){acc_nxt[W_SHORT-1]}}, acc_nxt[W_SHORT-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_sy <= '0; wclk_sy <= '0; sd_sy <= '0;
      wprev <= 1'b0; synced <= 1'b0; left_ok <= 1'b0;
      w20_q <= 1'b1; lsb_q <= 1'b0;
      pos <= '0; cnt <= '0; acc <= '0; left_hold <= '0;
      left_o <= '0; right_o <= '0; valid_o <= 1'b0; frame_err_o <= 1'b0;
    end else begin
      bclk_sy <= {bclk_sy[1:0], bclk_i};
      wclk_sy <= {wclk_sy[1:0], wclk_i};
      sd_sy   <= {sd_sy[1:0], sdata_i};
      valid_o <= 1'b0;
      if (ev) begin
        wprev <= wclk_s;
        acc   <= acc_nxt;
        pos   <= (pos_eff == PW'(SLOT_BITS-1)) ? pos_eff : pos_eff + PW'(1);
        if (wr_ev) begin
          synced      <= 1'b1;
          w20_q       <= cfg_w20_i;
          lsb_q       <= cfg_lsb_i;
          frame_err_o <= synced && (cnt != CW'(FRAME_BITS));
          cnt         <= CW'(1);
          left_ok     <= 1'b0;
        end else if (cnt != CNT_MAX) begin
          cnt <= cnt + CW'(1);
        end
        if (last_bit && synced) begin
          if (wclk_s) begin
            left_hold <= ext;
            left_ok   <= 1'b1;
          end else if (left_ok) begin
            left_o  <= left_hold;
            right_o <= ext;
            valid_o <= 1'b1;
          end
        end
      end
    end
  end

  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  p_hold_outputs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |=> ($stable(left_o) && $stable(right_o)) || valid_o);

  p_sign_ext_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !w20_q) |->
      (right_o[W_LONG-1:W_SHORT] == {(W_LONG-W_SHORT){right_o[W_SHORT-1]}}));

  p_err_at_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(frame_err_o) |-> $past(wr_ev));
endmodule

// File: tb/tb_stereo_serial_rx.sv
module tb_stereo_serial_rx;
  localparam int CLK_NS = 10;

  logic clk = 0, rst_n = 0;
  logic bclk_i = 0, wclk_i = 0, sdata_i = 0, cfg_w20_i = 1, cfg_lsb_i = 0;
  logic [19:0] left_o, right_o;
  logic valid_o, frame_err_o;

  stereo_serial_rx dut (.*);

  always #(CLK_NS/2) clk = ~clk;

  int checks = 0, fails = 0, vcount = 0;
  logic [19:0] capL = 0, capR = 0;
  int prev_len = 0;
  bit have_prev = 0;
  bit done = 0;

  always @(negedge clk) if (rst_n && valid_o) begin
    vcount++; capL = left_o; capR = right_o;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] expect_val(input logic [19:0] s, input bit w20);
    return w20 ? s : {{4{s[15]}}, s[15:0]};
  endfunction

  function automatic logic bit_at(input logic [19:0] s, input int p, input bit w20, input bit lsb, input logic junk);
    int w = w20 ? 20 : 16;
    if (p >= w) return junk;
    return lsb ? s[p] : s[w-1-p];
  endfunction

  task automatic send_bit(input logic w, input logic d);
    @(negedge clk); bclk_i = 0; wclk_i = w; sdata_i = d;
    repeat (2) @(negedge clk);
    bclk_i = 1;
    @(negedge clk);
  endtask

  task automatic send_frame(input logic [19:0] l, input logic [19:0] r, input bit w20,
                            input bit lsb, input int nbits, input bit chg);
    int v0 = vcount;
    @(negedge clk); cfg_w20_i = w20; cfg_lsb_i = lsb;
    for (int i = 0; i < nbits; i++) begin
      logic w = (i < 32);
      int p = w ? i : i - 32;
      logic d = bit_at(w ? l : r, p, w20, lsb, 1'($urandom));
      if (chg && i == 40) begin cfg_w20_i = ~w20; cfg_lsb_i = ~lsb; end
      send_bit(w, d);
    end
    chk(vcount == v0 + 1, "R6 one strobe per frame", vcount - v0, 1);
    chk(capL == expect_val(l, w20), w20 ? "R1 R3 R5 left" : "R1 R3 R4 R5 left", capL, expect_val(l, w20));
    chk(capR == expect_val(r, w20), chg ? "R7 right after mid-frame change" : "R2 R3 R5 right", capR, expect_val(r, w20));
    chk(frame_err_o == (have_prev && prev_len != 64), "R8 framing flag", frame_err_o, have_prev && prev_len != 64);
    have_prev = 1; prev_len = nbits;
  endtask

  initial begin
    void'($urandom(32'h5EED));
    repeat (4) @(negedge clk);
    chk(left_o == 0 && right_o == 0, "R9 reset outputs", {left_o, right_o}, 0);
    chk(!valid_o && !frame_err_o, "R9 reset flags", {valid_o, frame_err_o}, 0);
    rst_n = 1;
    for (int i = 0; i < 6; i++) send_bit(0, 1'($urandom));
    chk(vcount == 0, "R1 no strobe before first frame", vcount, 0);
    send_frame(20'h80001, 20'h7FFFF, 1, 0, 64, 0);
    send_frame(20'h08001, 20'h07FFE, 0, 1, 64, 0);
    send_frame(20'h0FFFF, 20'h00001, 0, 0, 64, 0);
    send_frame(20'hA5C3E, 20'h1B2D4, 1, 1, 64, 0);
    send_frame(20'h12345, 20'hFEDCB, 1, 0, 64, 1);
    send_frame(20'h0C0DE, 20'h0BEEF, 0, 1, 64, 1);
    send_frame(20'h11111, 20'h22222, 1, 0, 62, 0);
    send_frame(20'h33333, 20'h44444, 1, 1, 64, 0);
    send_frame(20'h55555, 20'h66666, 0, 0, 66, 0);
    send_frame(20'h77777, 20'h88888, 1, 0, 64, 0);
    send_frame(20'h99999, 20'hAAAAA, 0, 1, 64, 0);
    for (int k = 0; k < 20; k++)
      send_frame(20'($urandom), 20'($urandom), 1'($urandom), 1'($urandom), 64, 1'($urandom));
    repeat (10) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule